// File: doc/BRIEF.md
# Bus Wait-State Generator with Data-Request Auto-Wait

This block drives the active-low ready request that stretches CPU bus cycles for a disk controller board. It combines two independent sources of wait states. Their requests are merged into a single open-drain style pull-low signal.

The first source is a fixed inserter. It adds one wait state to every memory cycle that selects either the on-board ROM or the memory-mapped controller registers, which gives those slow parts more access time. A board strap turns it on or off. The second source is an auto-wait latch, enabled by software. Once bit 7 of control register 1 has been written as 1, an access to the controller's data register while the controller's data request (DRQ) is inactive holds the CPU in wait states. The CPU stays there for as many cycles as it takes until DRQ goes active.

A cycle start is taken from the bus sync pulse: by default from its rising edge, or from its level when so configured. Both wait sources are registered from that start, so the request shows up in the clock cycle after sync.

Top module: `bus_wait_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, `rdy_low` is 0. Reset clears the auto-wait enable, so a data-register access right after reset causes no wait.
- R2: With `strap_open`=1, a memory cycle (`mem_cycle`=1) whose sync rising edge comes with `rom_sel`=1 or `ctl_sel`=1 drives `rdy_low`=1 for exactly the one clock cycle after that edge. This holds even if `bus_sync` stays high for longer.
- R3: With `strap_open`=0 the fixed inserter never drives `rdy_low`.
- R4: A cycle with `mem_cycle`=0 (I/O cycle) never triggers the fixed inserter.
- R5: A pulse on `cr1_wr` loads `cr1_d7` into the auto-wait enable at that clock edge.
- R6: With auto-wait enabled and `drq`=0, a cycle start with `ctl_sel`=1 and `reg_sel`=2'b11 (the data register) sets the wait latch. `rdy_low` is 1 from the next cycle and stays 1 for as long as `drq` stays 0.
- R7: `drq`=1 releases the auto-wait request in the same cycle, with no clock edge needed. The latch is cleared at the next edge, so `drq` falling again afterwards does not bring the wait back.
- R8: Writing 0 to bit 7 of control register 1 clears a pending auto-wait at that write's clock edge.
- R9: Accesses with `reg_sel` of 2'b00, 2'b01 or 2'b10, and ROM accesses, never set the auto-wait latch.
- R10: A data-register access made while `drq`=1 does not set the latch, and no wait follows when `drq` later falls.
- R11: `rdy_low` is the OR of both sources. A memory-mapped data-register access with both sources active gives a continuous wait that ends when `drq` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| strap_open | input | 1 | 1 enables the fixed single-wait inserter |
| bus_sync | input | 1 | Bus cycle sync pulse |
| mem_cycle | input | 1 | 1 for a memory cycle, 0 for an I/O cycle |
| rom_sel | input | 1 | ROM is addressed |
| ctl_sel | input | 1 | Disk controller chip is addressed |
| reg_sel | input | SEL_W | Controller register select; all-ones is the data register |
| cr1_wr | input | 1 | Write strobe for control register 1 |
| cr1_d7 | input | 1 | Data bit 7 during that write (auto-wait enable) |
| drq | input | 1 | Controller data request, active high |
| rdy_low | output | 1 | 1 means pull the bus ready line low (wait) |

## Verification
The fixed wait is due in the single cycle after the clock edge that sees the sync rising edge, and must be gone one cycle after that. The auto-wait is due in the cycle after the starting edge. Its release is due in the same cycle that `drq` rises, with no clock edge in between. An enable write takes effect at the edge that samples the strobe. The bench drives every input just after a falling clock edge. It samples `rdy_low` one nanosecond later, in the half cycle after each edge of interest, so that every registered result and the combinational `drq` release are each read in the exact cycle they are due.

// File: rtl/bwg_pkg.sv
package bwg_pkg;

   // How a bus cycle start is derived from the sync pulse
   typedef enum logic {
      START_LEVEL = 1'b0,
      START_EDGE  = 1'b1
   } start_mode_e;

   // Combined per-source wait requests
   typedef struct packed {
      logic fixed_req;
      logic auto_req;
   } wait_src_t;

   function automatic logic any_wait(input wait_src_t s);
      return s.fixed_req | s.auto_req;
   endfunction

endpackage

// File: rtl/bwg_cycle_start.sv
module bwg_cycle_start
   import bwg_pkg::*;
#(
   parameter start_mode_e MODE = START_EDGE
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sync_in,
   output logic start_o
);

   generate
      if (MODE == START_EDGE) begin : g_edge
         logic sync_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= 1'b0;
            else        sync_q <= sync_in;
         end
         assign start_o = sync_in & ~sync_q;
      end else begin : g_level
         assign start_o = sync_in;
      end
   endgenerate

endmodule

// File: rtl/bwg_fixed_wait.sv
module bwg_fixed_wait #(
   parameter int unsigned WAITS = 1,
   localparam int unsigned CNT_W = (WAITS > 1) ? $clog2(WAITS + 1) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic enable_i,
   input  logic mem_cycle_i,
   input  logic target_i,
   output logic wait_o
);

   logic qualify;
   assign qualify = start_i & enable_i & mem_cycle_i & target_i;

   generate
      if (WAITS == 1) begin : g_single
         logic pend_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pend_q <= 1'b0;
            else        pend_q <= qualify;
         end
         assign wait_o = pend_q;
      end else begin : g_multi
         localparam logic [CNT_W-1:0] LOAD = CNT_W'(WAITS);
         logic [CNT_W-1:0] left_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)               left_q <= '0;
            else if (qualify)         left_q <= LOAD;
            else if (left_q != '0)    left_q <= left_q - 1'b1;
         end
         assign wait_o = (left_q != '0);
      end
   endgenerate

endmodule

// File: rtl/bwg_auto_wait.sv
module bwg_auto_wait #(
   parameter int unsigned SEL_W        = 2,
   parameter logic [SEL_W-1:0] DATA_SEL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             ctl_sel_i,
   input  logic [SEL_W-1:0] reg_sel_i,
   input  logic             cr1_wr_i,
   input  logic             cr1_d7_i,
   input  logic             drq_i,
   output logic             en_o,
   output logic             wait_o
);

   logic en_q;
   logic hold_q;
   logic data_access;

   assign data_access = start_i & ctl_sel_i & (reg_sel_i == DATA_SEL);

   // software enable, loaded on every control register 1 write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        en_q <= 1'b0;
      else if (cr1_wr_i) en_q <= cr1_d7_i;
   end

   // wait latch: kept clear while disabled or while DRQ is active
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                hold_q <= 1'b0;
      else if (!en_q || drq_i || (cr1_wr_i && !cr1_d7_i)) hold_q <= 1'b0;
      else if (data_access)                      hold_q <= 1'b1;
   end

   // DRQ releases ready without waiting for a clock edge
   assign wait_o = hold_q & ~drq_i;
   assign en_o   = en_q;

endmodule

// File: rtl/bus_wait_gen.sv
module bus_wait_gen
   import bwg_pkg::*;
#(
   parameter int unsigned SEL_W         = 2,
   parameter logic [SEL_W-1:0] DATA_SEL = '1,
   parameter int unsigned SINGLE_WAITS  = 1,
   parameter start_mode_e START_MODE    = START_EDGE
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             strap_open,
   input  logic             bus_sync,
   input  logic             mem_cycle,
   input  logic             rom_sel,
   input  logic             ctl_sel,
   input  logic [SEL_W-1:0] reg_sel,
   input  logic             cr1_wr,
   input  logic             cr1_d7,
   input  logic             drq,
   output logic             rdy_low
);

   generate
      if (SEL_W < 1 || SEL_W > 8) begin : g_bad_sel
         $error("bus_wait_gen: SEL_W must be 1..8");
      end
      if (SINGLE_WAITS < 1 || SINGLE_WAITS > 15) begin : g_bad_waits
         $error("bus_wait_gen: SINGLE_WAITS must be 1..15");
      end
   endgenerate

   logic      cyc_start;
   logic      fixed_wait;
   logic      auto_wait;
   logic      auto_en;
   wait_src_t srcs;

   bwg_cycle_start #(.MODE(START_MODE)) u_start (
      .clk     (clk),
      .rst_n   (rst_n),
      .sync_in (bus_sync),
      .start_o (cyc_start)
   );

   bwg_fixed_wait #(.WAITS(SINGLE_WAITS)) u_fixed (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (cyc_start),
      .enable_i    (strap_open),
      .mem_cycle_i (mem_cycle),
      .target_i    (rom_sel | ctl_sel),
      .wait_o      (fixed_wait)
   );

   bwg_auto_wait #(.SEL_W(SEL_W), .DATA_SEL(DATA_SEL)) u_auto (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (cyc_start),
      .ctl_sel_i (ctl_sel),
      .reg_sel_i (reg_sel),
      .cr1_wr_i  (cr1_wr),
      .cr1_d7_i  (cr1_d7),
      .drq_i     (drq),
      .en_o      (auto_en),
      .wait_o    (auto_wait)
   );

   assign srcs.fixed_req = fixed_wait;
   assign srcs.auto_req  = auto_wait;
   assign rdy_low        = any_wait(srcs);

endmodule

// File: rtl/bwg_checker.sv
module bwg_checker #(
   parameter int unsigned SINGLE_WAITS = 1
) (
   input logic clk,
   input logic rst_n,
   input logic strap_open,
   input logic bus_sync,
   input logic mem_cycle,
   input logic cr1_wr,
   input logic cr1_d7,
   input logic drq,
   input logic rdy_low,
   input logic fixed_w,
   input logic auto_w,
   input logic en_q
);

   // R1: quiet while in reset
   always @(posedge clk) begin
      if (!rst_n) begin
         p_reset_quiet_r1: assert (!rdy_low)
            else $error("rdy_low active during reset");
      end
   end

   generate
      if (SINGLE_WAITS == 1) begin : g_single_checks
         p_one_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
            fixed_w |=> !fixed_w);
         p_strap_closed_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !strap_open |=> !fixed_w);
         p_io_no_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_sync && !mem_cycle) |=> !fixed_w);
      end
   endgenerate

   p_enable_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cr1_wr |=> (en_q == $past(cr1_d7)));

   p_auto_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_w && !cr1_wr) |=> (auto_w || drq));

   p_drq_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      drq |-> !auto_w);

   p_disabled_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |-> !auto_w);

   p_source_shows_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (fixed_w || auto_w) |-> rdy_low);

endmodule

bind bus_wait_gen bwg_checker #(.SINGLE_WAITS(SINGLE_WAITS)) u_bwg_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .strap_open (strap_open),
   .bus_sync   (bus_sync),
   .mem_cycle  (mem_cycle),
   .cr1_wr     (cr1_wr),
   .cr1_d7     (cr1_d7),
   .drq        (drq),
   .rdy_low    (rdy_low),
   .fixed_w    (fixed_wait),
   .auto_w     (auto_wait),
   .en_q       (auto_en)
);

// File: tb/tb_bus_wait_gen.sv
`timescale 1ns/1ps
module tb_bus_wait_gen;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       strap_open = 1'b1;
   logic       bus_sync = 1'b0;
   logic       mem_cycle = 1'b0;
   logic       rom_sel = 1'b0;
   logic       ctl_sel = 1'b0;
   logic [1:0] reg_sel = 2'b00;
   logic       cr1_wr = 1'b0;
   logic       cr1_d7 = 1'b0;
   logic       drq = 1'b0;
   logic       rdy_low;

   int checks = 0;
   int failures = 0;

   always #10 clk = ~clk;

   bus_wait_gen dut (
      .clk(clk), .rst_n(rst_n), .strap_open(strap_open), .bus_sync(bus_sync),
      .mem_cycle(mem_cycle), .rom_sel(rom_sel), .ctl_sel(ctl_sel),
      .reg_sel(reg_sel), .cr1_wr(cr1_wr), .cr1_d7(cr1_d7), .drq(drq),
      .rdy_low(rdy_low)
   );

   task automatic chk(input string req, input logic exp);
      checks++;
      if (rdy_low !== exp) begin
         failures++;
         $display("FAIL %s: rdy_low=%b expected=%b at %0t", req, rdy_low, exp, $time);
      end
   endtask

   task automatic idle();
      @(negedge clk);
      bus_sync = 0; mem_cycle = 0; rom_sel = 0; ctl_sel = 0; reg_sel = 0;
      cr1_wr = 0;
   endtask

   // one-cycle sync; returns one ns after the edge that saw the start
   task automatic start_cycle(input logic mem, input logic rom, input logic ctl,
                              input logic [1:0] sel);
      @(negedge clk);
      bus_sync = 1; mem_cycle = mem; rom_sel = rom; ctl_sel = ctl; reg_sel = sel;
      @(negedge clk);
      bus_sync = 0;
      #1;
   endtask

   task automatic write_cr1(input logic d7);
      @(negedge clk);
      cr1_wr = 1; cr1_d7 = d7;
      @(negedge clk);
      cr1_wr = 0;
   endtask

   task automatic t_reset();
      #1 chk("R1 in reset", 1'b0);
      repeat (2) @(negedge clk);
      rst_n = 1;
      @(negedge clk); #1 chk("R1 after release", 1'b0);
      start_cycle(1'b0, 1'b0, 1'b1, 2'b11);
      chk("R1 enable cleared by reset", 1'b0);
      @(negedge clk); #1 chk("R1 enable cleared, later", 1'b0);
      idle();
   endtask

   task automatic t_fixed_rom();
      strap_open = 1;
      start_cycle(1'b1, 1'b1, 1'b0, 2'b00);
      chk("R2 rom wait", 1'b1);
      @(negedge clk); #1 chk("R2 rom wait ends", 1'b0);
      idle();
   endtask

   task automatic t_fixed_long_sync();
      @(negedge clk);
      bus_sync = 1; mem_cycle = 1; ctl_sel = 1; reg_sel = 2'b01;
      @(negedge clk); #1 chk("R2 ctl wait, sync still high", 1'b1);
      @(negedge clk); #1 chk("R2 only one wait for long sync", 1'b0);
      bus_sync = 0;
      @(negedge clk); #1 chk("R2 no second wait", 1'b0);
      idle();
   endtask

   task automatic t_strap_closed();
      strap_open = 0;
      start_cycle(1'b1, 1'b1, 1'b0, 2'b00);
      chk("R3 strap closed no wait", 1'b0);
      @(negedge clk); #1 chk("R3 strap closed later", 1'b0);
      strap_open = 1;
      idle();
   endtask

   task automatic t_io_cycle();
      start_cycle(1'b0, 1'b1, 1'b0, 2'b00);
      chk("R4 io cycle no fixed wait", 1'b0);
      idle();
   endtask

   task automatic t_auto_basic();
      write_cr1(1'b1);
      start_cycle(1'b0, 1'b0, 1'b1, 2'b11);
      chk("R5 enable loaded, R6 wait starts", 1'b1);
      for (int i = 0; i < 5; i++) begin
         @(negedge clk); #1 chk("R6 wait held while drq low", 1'b1);
      end
      @(negedge clk); drq = 1;
      #1 chk("R7 drq releases same cycle", 1'b0);
      @(negedge clk); drq = 0;
      #1 chk("R7 latch cleared after drq", 1'b0);
      idle();
   endtask

   task automatic t_auto_other_sel();
      for (int a = 0; a < 3; a++) begin
         start_cycle(1'b0, 1'b0, 1'b1, 2'(a));
         chk("R9 non-data register no wait", 1'b0);
      end
      start_cycle(1'b0, 1'b1, 1'b0, 2'b11);
      chk("R9 rom access no auto wait", 1'b0);
      idle();
   endtask

   task automatic t_auto_drq_high();
      @(negedge clk); drq = 1;
      start_cycle(1'b0, 1'b0, 1'b1, 2'b11);
      chk("R10 drq high at access", 1'b0);
      drq = 0;
      #1 chk("R10 no wait after drq falls", 1'b0);
      @(negedge clk); #1 chk("R10 still no wait", 1'b0);
      idle();
   endtask

   task automatic t_auto_disable();
      start_cycle(1'b0, 1'b0, 1'b1, 2'b11);
      chk("R8 armed before disable", 1'b1);
      @(negedge clk);
      cr1_wr = 1; cr1_d7 = 0;
      #1 chk("R8 still waiting before write edge", 1'b1);
      @(negedge clk); cr1_wr = 0;
      #1 chk("R8 disable write clears wait", 1'b0);
      start_cycle(1'b0, 1'b0, 1'b1, 2'b11);
      chk("R8 disabled no new wait", 1'b0);
      idle();
   endtask

   task automatic t_both_sources();
      write_cr1(1'b1);
      strap_open = 1;
      start_cycle(1'b1, 1'b0, 1'b1, 2'b11);
      chk("R11 both sources wait", 1'b1);
      @(negedge clk); #1 chk("R11 auto continues after fixed", 1'b1);
      @(negedge clk); drq = 1;
      #1 chk("R11 drq ends combined wait", 1'b0);
      @(negedge clk); drq = 0;
      idle();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      t_reset();
      t_fixed_rom();
      t_fixed_long_sync();
      t_strap_closed();
      t_io_cycle();
      t_auto_basic();
      t_auto_other_sel();
      t_auto_drq_high();
      t_auto_disable();
      t_both_sources();
      repeat (2) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule